// File: doc/BRIEF.md
# FIFO Status and Interrupt Unit

This block watches the receive-side and transmit-side FIFOs of a serial peripheral controller and turns what it sees into a twelve-bit level status vector, an edge-latched interrupt cause register and one interrupt line. It takes each FIFO's occupancy count and its push and pop strobes. From these it derives empty, full and ready flags. It also keeps sticky overflow and underflow flags. Two transfer-engine levels, done and ready, are passed into the same vector so that every status source reaches the interrupt logic in one place.

A cause bit is latched only when its status bit goes from low to high, so software that finds a condition already high must poll the status vector rather than wait for an interrupt. Causes are cleared by writing ones, and the line is the OR of the causes that are enabled in a mask. A flush request clears the sticky error flags and drives a flush command to the FIFO storage. The unit drops the command by itself once both FIFOs report zero occupancy.

The ready thresholds come from a shared configuration word. The receive threshold sits in bits 26:24 and is programmed as the word size in bytes minus one. The transmit threshold sits in bits 30:28 and is programmed as seven minus the word size in bytes. For 4-byte words, both fields therefore hold 3.

Top module: `fifo_stat_irq`

## Requirements
- R1: The status bit order is fixed. Bit 0 is transfer done and bit 1 is transfer ready, both copied from inputs. Bit 4 is receive empty (occupancy 0) and bit 5 is receive full (occupancy DEPTH). Bits 6 and 7 are the transmit empty and full flags under the same rules. These bits follow the inputs in the same cycle.
- R2: Status bit 2 (receive ready) is high exactly when the receive occupancy is greater than cfg_word[26:24].
- R3: Status bit 3 (transmit ready) is high exactly when the transmit free space (DEPTH minus occupancy) is greater than cfg_word[30:28].
- R4: A push while a FIFO is full with no pop in the same cycle sets its overflow flag, which is bit 9 for receive and bit 11 for transmit. A pop while a FIFO is empty with no push sets its underflow flag, which is bit 8 for receive and bit 10 for transmit. A push and a pop in the same cycle set neither flag. A flag becomes visible after the clock edge that samples the strobe.
- R5: Overflow and underflow flags stay set until a flush request is accepted or reset is applied.
- R6: A cause bit is set at the clock edge after its status bit has changed from 0 to 1. A status bit that stays high raises no new cause after that cause has been cleared.
- R7: Writing 1 to a bit of cause_clr clears that cause bit at the next edge. Bits written with 0 have no effect.
- R8: If a 0-to-1 status change and a clear of the same cause bit happen in the same cycle, the cause bit stays set.
- R9: irq is high exactly when a set cause bit has its mask bit set. The mask is loaded from mask_wdata at an edge where mask_we is high, and it resets to all zero.
- R10: A flush request taken while no flush is busy raises flush_busy at the next edge. flush_busy falls at the first edge at which both occupancies are zero.
- R11: After reset, cause, mask, sticky flags and flush_busy are zero. Status bits that are high when reset releases raise no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word; receive threshold in bits 26:24, transmit threshold in bits 30:28 |
| rd_push | input | 1 | Receive FIFO write strobe |
| rd_pop | input | 1 | Receive FIFO read strobe |
| rd_level | input | LVL_W | Receive FIFO occupancy |
| wr_push | input | 1 | Transmit FIFO write strobe |
| wr_pop | input | 1 | Transmit FIFO read strobe |
| wr_level | input | LVL_W | Transmit FIFO occupancy |
| xfer_done | input | 1 | Transfer engine done level |
| xfer_ready | input | 1 | Transfer engine ready level |
| flush_req | input | 1 | Request to flush both FIFOs |
| mask_we | input | 1 | Load strobe for the interrupt mask |
| mask_wdata | input | 12 | New interrupt mask value |
| cause_clr | input | 12 | Write-one-to-clear vector for the cause register |
| status | output | 12 | Level status vector |
| cause | output | 12 | Latched interrupt causes |
| irq | output | 1 | Interrupt line |
| flush_busy | output | 1 | Flush command to the FIFO storage, high until both FIFOs are empty |

## Verification
A stale previous-status register shows up at the ports as a cause bit that appears one edge after a status bit rises without any real transition, or that fails to appear after a real one. In both cases the error is visible on the cause outputs at the very next edge. A sticky flag that leaks shows as a status bit 8 to 11 falling without a flush request in the cycle before. A flush controller that is stuck shows as flush_busy staying high past the first edge with both occupancies at zero. The threshold compares are combinational, so any off-by-one error is visible on status in the same cycle that the occupancy or the field changes.

// File: rtl/fsi_pkg.sv
package fsi_pkg;

    localparam int STAT_W     = 12;
    localparam int THR_W      = 3;
    localparam int RD_THR_LSB = 24;
    localparam int WR_THR_LSB = 28;

    // status bit positions (software decodes these)
    localparam int ST_DONE     = 0;
    localparam int ST_XRDY     = 1;
    localparam int ST_RD_RDY   = 2;
    localparam int ST_WR_RDY   = 3;
    localparam int ST_RD_EMPTY = 4;
    localparam int ST_RD_FULL  = 5;
    localparam int ST_WR_EMPTY = 6;
    localparam int ST_WR_FULL  = 7;
    localparam int ST_RD_UNF   = 8;
    localparam int ST_RD_OVF   = 9;
    localparam int ST_WR_UNF   = 10;
    localparam int ST_WR_OVF   = 11;

    typedef struct packed {
        logic ovf;
        logic unf;
    } sticky_t;

    typedef struct packed {
        logic [STAT_W-1:0] cause;
        logic [STAT_W-1:0] mask;
        logic [STAT_W-1:0] prev;
    } cause_state_t;

endpackage

// File: rtl/fsi_side_mon.sv
module fsi_side_mon
    import fsi_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int LVL_W      = $clog2(DEPTH + 1),
    parameter bit WRITE_SIDE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thr,
    input  logic             clear_sticky,
    output logic             rdy,
    output logic             empty,
    output logic             full,
    output logic             ovf,
    output logic             unf
);

    localparam int CW = LVL_W + 1;

    sticky_t st_d, st_q;
    logic [CW-1:0] thr_x;
    logic [CW-1:0] lvl_x;

    assign thr_x = CW'(thr);
    assign lvl_x = CW'(level);
    assign empty = (level == '0);
    assign full  = (level == LVL_W'(DEPTH));

    generate
        if (WRITE_SIDE) begin : g_free
            logic [CW-1:0] space;
            assign space = CW'(DEPTH) - lvl_x;
            assign rdy   = (space > thr_x);
        end else begin : g_occ
            assign rdy = (lvl_x > thr_x);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clear_sticky) begin
            st_d = '0;
        end else begin
            if (push && !pop && full) st_d.ovf = 1'b1;
            if (pop && !push && empty) st_d.unf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf = st_q.ovf;
    assign unf = st_q.unf;

endmodule

// File: rtl/fsi_cause_unit.sv
module fsi_cause_unit
    import fsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic [STAT_W-1:0] clr,
    output logic [STAT_W-1:0] cause,
    output logic              irq
);

    cause_state_t cs_d, cs_q;
    logic [STAT_W-1:0] rise;

    always_comb begin
        cs_d      = cs_q;
        rise      = status & ~cs_q.prev;
        cs_d.prev = status;
        // a fresh edge wins over a clear of the same bit
        cs_d.cause = (cs_q.cause & ~clr) | rise;
        if (mask_we) cs_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.cause <= '0;
            cs_q.mask  <= '0;
            cs_q.prev  <= '1;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign cause = cs_q.cause;
    assign irq   = |(cs_q.cause & cs_q.mask);

endmodule

// File: rtl/fsi_flush_ctrl.sv
module fsi_flush_ctrl #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LVL_W-1:0] rd_level,
    input  logic [LVL_W-1:0] wr_level,
    output logic             start,
    output logic             busy
);

    logic busy_d, busy_q;
    logic drained;

    assign drained = (rd_level == '0) && (wr_level == '0);
    assign start   = req && !busy_q;

    always_comb begin
        busy_d = busy_q;
        if (busy_q) busy_d = !drained;
        else        busy_d = req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign busy = busy_q;

endmodule

// File: rtl/fifo_stat_irq.sv
module fifo_stat_irq
    import fsi_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic              rd_push,
    input  logic              rd_pop,
    input  logic [LVL_W-1:0]  rd_level,
    input  logic              wr_push,
    input  logic              wr_pop,
    input  logic [LVL_W-1:0]  wr_level,
    input  logic              xfer_done,
    input  logic              xfer_ready,
    input  logic              flush_req,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic [STAT_W-1:0] cause_clr,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] cause,
    output logic              irq,
    output logic              flush_busy
);

    localparam int NSIDE = 2;   // index 0 receive, 1 transmit

    logic             s_push  [NSIDE];
    logic             s_pop   [NSIDE];
    logic [LVL_W-1:0] s_level [NSIDE];
    logic [THR_W-1:0] s_thr   [NSIDE];
    logic             s_rdy   [NSIDE];
    logic             s_empty [NSIDE];
    logic             s_full  [NSIDE];
    logic             s_ovf   [NSIDE];
    logic             s_unf   [NSIDE];
    logic             flush_start;
    logic             cfg_unused;

    assign cfg_unused = ^{cfg_word[31], cfg_word[27], cfg_word[23:0]};

    assign s_push[0]  = rd_push;
    assign s_pop[0]   = rd_pop;
    assign s_level[0] = rd_level;
    assign s_thr[0]   = cfg_word[RD_THR_LSB +: THR_W];
    assign s_push[1]  = wr_push;
    assign s_pop[1]   = wr_pop;
    assign s_level[1] = wr_level;
    assign s_thr[1]   = cfg_word[WR_THR_LSB +: THR_W];

    generate
        for (genvar g = 0; g < NSIDE; g++) begin : g_side
            fsi_side_mon #(
                .DEPTH      (DEPTH),
                .LVL_W      (LVL_W),
                .WRITE_SIDE (g == 1)
            ) u_mon (
                .clk          (clk),
                .rst_n        (rst_n),
                .push         (s_push[g]),
                .pop          (s_pop[g]),
                .level        (s_level[g]),
                .thr          (s_thr[g]),
                .clear_sticky (flush_start),
                .rdy          (s_rdy[g]),
                .empty        (s_empty[g]),
                .full         (s_full[g]),
                .ovf          (s_ovf[g]),
                .unf          (s_unf[g])
            );
        end
    endgenerate

    fsi_flush_ctrl #(.LVL_W(LVL_W)) u_flush (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (flush_req),
        .rd_level (rd_level),
        .wr_level (wr_level),
        .start    (flush_start),
        .busy     (flush_busy)
    );

    always_comb begin
        status              = '0;
        status[ST_DONE]     = xfer_done;
        status[ST_XRDY]     = xfer_ready;
        status[ST_RD_RDY]   = s_rdy[0];
        status[ST_WR_RDY]   = s_rdy[1];
        status[ST_RD_EMPTY] = s_empty[0];
        status[ST_RD_FULL]  = s_full[0];
        status[ST_WR_EMPTY] = s_empty[1];
        status[ST_WR_FULL]  = s_full[1];
        status[ST_RD_UNF]   = s_unf[0];
        status[ST_RD_OVF]   = s_ovf[0];
        status[ST_WR_UNF]   = s_unf[1];
        status[ST_WR_OVF]   = s_ovf[1];
    end

    fsi_cause_unit u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .status     (status),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .clr        (cause_clr),
        .cause      (cause),
        .irq        (irq)
    );

endmodule

// File: rtl/fifo_stat_irq_chk.sv
module fifo_stat_irq_chk
    import fsi_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  rd_level,
    input logic [LVL_W-1:0]  wr_level,
    input logic              flush_req,
    input logic [STAT_W-1:0] cause_clr,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] cause,
    input logic              irq,
    input logic              flush_busy
);

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status[ST_RD_EMPTY], status[ST_RD_FULL]}) && $onehot0({status[ST_WR_EMPTY], status[ST_WR_FULL]})); // R1

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status[ST_WR_OVF:ST_RD_UNF]) & ~status[ST_WR_OVF:ST_RD_UNF])) |-> $past(flush_req)); // R5

    AST_CAUSE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cause & ~$past(cause) & ~$past(status)) == '0); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cause & $past(cause & cause_clr) & ~$past(status)) == '0); // R7

    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cause != '0)); // R9

    AST_FLUSH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_busy) |=> flush_busy); // R10

    AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_busy && rd_level == '0 && wr_level == '0) |=> !flush_busy); // R10

endmodule

bind fifo_stat_irq fifo_stat_irq_chk #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_level   (rd_level),
    .wr_level   (wr_level),
    .flush_req  (flush_req),
    .cause_clr  (cause_clr),
    .status     (status),
    .cause      (cause),
    .irq        (irq),
    .flush_busy (flush_busy)
);

// File: tb/fifo_stat_irq_bench.sv
module fifo_stat_irq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LVL_W      = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_word;
    logic        rd_push, rd_pop, wr_push, wr_pop;
    logic [LVL_W-1:0] rd_level, wr_level;
    logic        xfer_done, xfer_ready, flush_req, mask_we;
    logic [11:0] mask_wdata, cause_clr;
    logic [11:0] status, cause;
    logic        irq, flush_busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_stat_irq #(.DEPTH(DEPTH)) u_fifo_stat_irq (
        .clk, .rst_n, .cfg_word, .rd_push, .rd_pop, .rd_level,
        .wr_push, .wr_pop, .wr_level, .xfer_done, .xfer_ready,
        .flush_req, .mask_we, .mask_wdata, .cause_clr,
        .status, .cause, .irq, .flush_busy
    );

    // {rd_level, wr_level, rd_thr, wr_thr, done, ready, expected status[7:0]}
    // thresholds 3/3 encode 4-byte words; 0/7 and 7/0 probe the field ends
    localparam logic [23:0] VECS [8] = '{
        {4'd0, 4'd0, 3'd3, 3'd3, 1'b0, 1'b0, 8'h58},
        {4'd4, 4'd4, 3'd3, 3'd3, 1'b1, 1'b0, 8'h0D},
        {4'd3, 4'd5, 3'd3, 3'd3, 1'b0, 1'b1, 8'h02},
        {4'd8, 4'd8, 3'd0, 3'd7, 1'b0, 1'b0, 8'hA4},
        {4'd1, 4'd1, 3'd0, 3'd7, 1'b1, 1'b1, 8'h07},
        {4'd0, 4'd0, 3'd7, 3'd7, 1'b0, 1'b0, 8'h58},
        {4'd7, 4'd0, 3'd7, 3'd0, 1'b0, 1'b0, 8'h48},
        {4'd8, 4'd7, 3'd7, 3'd0, 1'b0, 1'b0, 8'h2C}
    };

    function automatic logic [31:0] mk_cfg(input logic [2:0] rt, input logic [2:0] wt);
        return (32'(rt) << 24) | (32'(wt) << 28);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        report();
    end

    initial begin
        rst_n = 1'b0; cfg_word = mk_cfg(3'd3, 3'd3);
        rd_push = 0; rd_pop = 0; wr_push = 0; wr_pop = 0;
        rd_level = 0; wr_level = 0; xfer_done = 0; xfer_ready = 0;
        flush_req = 0; mask_we = 0; mask_wdata = 0; cause_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(); step(); step();
        // R11: reset state; high status at release raises no cause
        chk(cause == 12'h000, "R11 cause", cause, 0);
        chk(irq == 1'b0, "R11 irq", irq, 0);
        chk(flush_busy == 1'b0, "R11 flush", flush_busy, 0);
        chk(status == 12'h058, "R1 reset status", status, 12'h058);

        // R1 R2 R3: table walk of level flags and thresholds
        for (int i = 0; i < 8; i++) begin
            rd_level   = VECS[i][23:20];
            wr_level   = VECS[i][19:16];
            cfg_word   = mk_cfg(VECS[i][15:13], VECS[i][12:10]);
            xfer_done  = VECS[i][9];
            xfer_ready = VECS[i][8];
            #1;
            chk(status[7:0] == VECS[i][7:0], "R1/R2/R3 vector", status, VECS[i][7:0]);
            chk(status[11:8] == 4'h0, "R4 no sticky in table", status[11:8], 0);
            @(negedge clk);
        end

        rd_level = 4; wr_level = 4; cfg_word = mk_cfg(3'd3, 3'd3);
        xfer_done = 0; xfer_ready = 0;
        step();
        cause_clr = 12'hFFF; step(); cause_clr = 0;
        chk(cause == 12'h000, "R7 clear all", cause, 0);

        xfer_done = 1; step();
        chk(cause == 12'h001, "R6 edge sets cause", cause, 1);
        chk(irq == 1'b0, "R9 unmasked off", irq, 0);
        mask_we = 1; mask_wdata = 12'h002; step(); mask_we = 0;
        chk(irq == 1'b0, "R9 other bit masked", irq, 0);
        mask_we = 1; mask_wdata = 12'h001; step(); mask_we = 0;
        chk(irq == 1'b1, "R9 enabled", irq, 1);

        cause_clr = 12'h002; step(); cause_clr = 0;
        chk(cause == 12'h001, "R7 zero bits no effect", cause, 1);
        cause_clr = 12'h001; step(); cause_clr = 0;
        chk(cause == 12'h000, "R7 clear bit0", cause, 0);
        step(); step();
        chk(cause == 12'h000, "R6 held level no re-raise", cause, 0);
        chk(irq == 1'b0, "R9 irq drops", irq, 0);

        xfer_done = 0; step();
        xfer_done = 1; cause_clr = 12'h001; step(); cause_clr = 0;
        chk(cause == 12'h001, "R8 edge beats clear", cause, 1);
        cause_clr = 12'hFFF; step(); cause_clr = 0;

        // R4 receive overflow
        rd_level = 8; rd_push = 1; step(); rd_push = 0; rd_level = 4;
        chk(status[9] == 1'b1, "R4 rd overflow", status[9], 1);
        step();
        chk(cause[9] == 1'b1, "R6 overflow cause", cause[9], 1);
        chk(status[9] == 1'b1, "R5 overflow sticky", status[9], 1);

        // R4 push with pop at full: no flag
        wr_level = 8; wr_push = 1; wr_pop = 1; step(); wr_push = 0; wr_pop = 0;
        chk(status[11] == 1'b0, "R4 push+pop full", status[11], 0);
        wr_level = 0; wr_pop = 1; step(); wr_pop = 0;
        chk(status[10] == 1'b1, "R4 wr underflow", status[10], 1);
        rd_level = 0; rd_pop = 1; rd_push = 1; step(); rd_push = 0;
        chk(status[8] == 1'b0, "R4 pop+push empty", status[8], 0);
        step(); rd_pop = 0;
        chk(status[8] == 1'b1, "R4 rd underflow", status[8], 1);
        chk(status[11:8] == 4'h7, "R5 flags held", status[11:8], 4'h7);

        // R10 flush with data present
        rd_level = 3; wr_level = 2;
        flush_req = 1; step(); flush_req = 0;
        chk(flush_busy == 1'b1, "R10 flush starts", flush_busy, 1);
        chk(status[11:8] == 4'h0, "R5 flush clears sticky", status[11:8], 0);
        step(); step();
        chk(flush_busy == 1'b1, "R10 busy while data", flush_busy, 1);
        rd_level = 0; wr_level = 0; step();
        chk(flush_busy == 1'b0, "R10 flush ends", flush_busy, 0);
        flush_req = 1; step(); flush_req = 0;
        chk(flush_busy == 1'b1, "R10 empty flush starts", flush_busy, 1);
        step();
        chk(flush_busy == 1'b0, "R10 empty flush ends", flush_busy, 0);

        // R11 reset mid-state
        wr_pop = 1; step(); wr_pop = 0;
        mask_we = 1; mask_wdata = 12'hFFF; step(); mask_we = 0;
        chk(irq == 1'b1, "R9 irq before reset", irq, 1);
        rst_n = 0; @(negedge clk); rst_n = 1; step();
        chk(cause == 12'h000, "R11 cause after reset", cause, 0);
        chk(irq == 1'b0, "R11 mask after reset", irq, 0);
        chk(status[11:8] == 4'h0, "R11 sticky after reset", status[11:8], 0);

        report();
    end

endmodule